// File: doc/BRIEF.md
# SATA Host Port Command and Task-File Register

This block holds the per-port control register and the task-file status register of a SATA host port. Software writes the control word over a simple register bus. The block turns those writes into single-cycle requests to the rest of the port. A rising spin-up bit asks the link layer for a COMRESET sequence. A rising start bit tells the command fetcher to begin at slot 0. The block also keeps the command-issue bit vector, and clears it when command processing stops and the engine has gone idle.

Received device FISes pass through an acceptance gate. While FIS reception is disabled, every FIS is dropped, with one exception: the first device-to-host register FIS after an initialization sequence is still taken. Accepted FISes update the status and error bytes of the task-file register. An override bit lets software clear BSY and DRQ before it sends a software reset. The hardware clears that bit again by itself.

Top module: `sata_port_ctl_reg`

## Requirements
- R1: After reset, address 0 (control) reads 0x00000004 when `stagger_cap` is 1, address 1 (task file) reads 0x0000007F, address 2 (command issue) reads 0, and address 3 always reads 0.
- R2: Control bit 4 enables FIS reception. While it is 0, a FIS on `fis_valid` leaves the task file unchanged, apart from the exception in R3. FIS types are encoded as 0 = device-to-host register, 1 = PIO setup, 2 = set-device-bits and 3 = other.
- R3: A pulse on `init_done` arms a single exception. The next type-0 FIS is accepted even while bit 4 is 0, and accepting it disarms the exception. FISes of other types are not covered by the exception.
- R4: Control bit 14 reads 1 one cycle after bit 4 is set. After bit 4 is cleared, bit 14 stays at 1 while `rx_busy` is high, and falls once `rx_busy` is low.
- R5: Writing 1 to control bit 3 forces task-file bits 7 (BSY) and 3 (DRQ) to 0. Bit 3 then reads 1 for one cycle and clears itself once BSY and DRQ are both 0. Writing 0 to bit 3 changes nothing.
- R6: Control bit 2 always reads 1, and writes do not affect it.
- R7: When `stagger_cap` is 1, control bit 1 is read/write and resets to 0. When `stagger_cap` is 0, bit 1 reads 1 and writes do not change it.
- R8: Writing bit 1 from 0 to 1 while `stagger_cap` is 1 drives `comreset_req` high for exactly one clock, in the cycle after the write. Writing 1 to a bit that is already 1, or writing it while `stagger_cap` is 0, gives no pulse.
- R9: Writing control bit 0 from 0 to 1 drives `start_slot0` high for exactly one clock, in the cycle after the write. Writing 1 again while the bit is already 1 gives no pulse.
- R10: Control bit 15 reads 1 from the cycle after bit 0 is set. After bit 0 is cleared, bit 15 and the command-issue vector keep their values until `engine_idle` is 1. In that cycle both clear to 0.
- R11: An accepted type-0 or type-1 FIS loads the status byte into task-file bits 7:0 and the error byte into bits 15:8. A type-2 FIS loads the error byte and status bits 6:4 and 2:0, and keeps the old BSY and DRQ. A type-3 FIS leaves the task file unchanged.
- R12: A write to address 2 ORs its data into the command-issue vector only while control bit 0 is 1. At any other time the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stagger_cap | input | 1 | Staggered spin-up capability |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 2 command issue |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| init_done | input | 1 | Pulse when a link initialization sequence completes |
| fis_valid | input | 1 | Received FIS present this cycle |
| fis_type | input | 2 | Received FIS type |
| fis_status | input | 8 | Status byte of the FIS |
| fis_error | input | 8 | Error byte of the FIS |
| fis_accept | output | 1 | FIS is accepted this cycle |
| rx_busy | input | 1 | Receive path still moving data |
| engine_idle | input | 1 | Command engine is idle |
| comreset_req | output | 1 | One-cycle COMRESET request |
| start_slot0 | output | 1 | One-cycle start-at-slot-0 request |
| cmd_issue | output | SLOTS | Command-issue vector |

## Verification
The bench builds the block with SLOTS = 8. With that width, a write to the top slot bit shows that the command-issue vector is masked and zero-extended correctly, and that a stop clears the whole vector. The bench drives `stagger_cap` both high and low during a single run. This covers the read/write and the fixed-1 forms of the spin-up bit, and it shows that no COMRESET request is issued while the capability is absent.

// File: rtl/sata_port_ctl_reg.sv
module sata_port_ctl_reg #(
  parameter int SLOTS = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stagger_cap,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             init_done,
  input  logic             fis_valid,
  input  logic [1:0]       fis_type,
  input  logic [7:0]       fis_status,
  input  logic [7:0]       fis_error,
  output logic             fis_accept,
  input  logic             rx_busy,
  input  logic             engine_idle,
  output logic             comreset_req,
  output logic             start_slot0,
  output logic [SLOTS-1:0] cmd_issue
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_TF  = 2'd1;
  localparam logic [1:0] A_CI  = 2'd2;
  localparam logic [1:0] T_D2H = 2'd0;
  localparam logic [1:0] T_PIO = 2'd1;
  localparam logic [1:0] T_SDB = 2'd2;

  logic       run_q, spin_q, ovr_q, rxen_q, rxrun_q, cmdrun_q, armed_q;
  logic [7:0] sts_q, err_q, sts_d;
  logic [SLOTS-1:0] ci_q;

  wire ctl_wr = wr_en && wr_addr == A_CTL;
  wire ci_wr  = wr_en && wr_addr == A_CI;
  wire ovr_wr = ctl_wr && wr_data[3];
  wire spin_rd = stagger_cap ? spin_q : 1'b1;
  wire stop_done = !run_q && cmdrun_q && engine_idle;

  assign fis_accept = fis_valid && (rxen_q || (armed_q && fis_type == T_D2H));

  always_comb begin
    sts_d = sts_q;
    if (fis_accept) begin
      if (fis_type == T_D2H || fis_type == T_PIO)
        sts_d = fis_status;
      else if (fis_type == T_SDB)
        sts_d = (sts_q & 8'h88) | (fis_status & 8'h77);
    end
    if (ovr_wr) begin
      sts_d[7] = 1'b0;
      sts_d[3] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; spin_q <= 1'b0; ovr_q <= 1'b0; rxen_q <= 1'b0;
      rxrun_q <= 1'b0; cmdrun_q <= 1'b0; armed_q <= 1'b0;
      sts_q <= 8'h7F; err_q <= 8'h00; ci_q <= '0;
      comreset_req <= 1'b0; start_slot0 <= 1'b0;
    end else begin
      comreset_req <= ctl_wr && wr_data[1] && stagger_cap && !spin_q;
      start_slot0  <= ctl_wr && wr_data[0] && !run_q;
      if (ctl_wr) begin
        run_q  <= wr_data[0];
        rxen_q <= wr_data[4];
        if (stagger_cap) spin_q <= wr_data[1];
      end
      if (ovr_wr) ovr_q <= 1'b1;
      else if (ovr_q && !sts_q[7] && !sts_q[3]) ovr_q <= 1'b0;
      rxrun_q  <= rxen_q || (rxrun_q && rx_busy);
      cmdrun_q <= run_q || (cmdrun_q && !engine_idle);
      if (init_done) armed_q <= 1'b1;
      else if (fis_accept && fis_type == T_D2H) armed_q <= 1'b0;
      sts_q <= sts_d;
      if (fis_accept && fis_type != 2'd3) err_q <= fis_error;
      if (stop_done) ci_q <= '0;
      else if (ci_wr && run_q) ci_q <= ci_q | wr_data[SLOTS-1:0];
    end
  end

  assign cmd_issue = ci_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTL: begin
        rd_data[0]  = run_q;
        rd_data[1]  = spin_rd;
        rd_data[2]  = 1'b1;
        rd_data[3]  = ovr_q;
        rd_data[4]  = rxen_q;
        rd_data[14] = rxrun_q;
        rd_data[15] = cmdrun_q;
      end
      A_TF: rd_data[15:0] = {err_q, sts_q};
      A_CI: rd_data[SLOTS-1:0] = ci_q;
      default: rd_data = '0;
    endcase
  end

  // R5
  ovr_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_wr |=> (!sts_q[7] && !sts_q[3]));
  // R8
  comreset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comreset_req |=> !comreset_req);
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_slot0 |=> !start_slot0);
  // R10
  stop_clears_ci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmdrun_q) |-> ci_q == '0);
  // R10
  stop_waits_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdrun_q && !run_q && !engine_idle) |=> ($stable(ci_q) && cmdrun_q));
  // R2
  drop_keeps_tf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fis_valid && !rxen_q && fis_type != T_D2H && !ovr_wr) |=> $stable({err_q, sts_q}));
endmodule

// File: tb/sata_port_ctl_reg_bench.sv
module sata_port_ctl_reg_bench;
  localparam int PERIOD = 10;
  localparam int SL = 8;
  localparam int NV = 8;
  // {type, status, error, expected task file}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'h50, 8'h00, 16'h0050},
    {2'd1, 8'hD8, 8'h01, 16'h01D8},
    {2'd2, 8'h41, 8'h04, 16'h04C9},
    {2'd2, 8'hFF, 8'h00, 16'h00FF},
    {2'd0, 8'h00, 8'h00, 16'h0000},
    {2'd2, 8'h88, 8'h10, 16'h1000},
    {2'd3, 8'hAA, 8'hAA, 16'h1000},
    {2'd1, 8'h08, 8'h00, 16'h0008}
  };

  logic clk = 0, rst_n = 0, stagger_cap = 1, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0, fis_type = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic init_done = 0, fis_valid = 0, rx_busy = 0, engine_idle = 1;
  logic [7:0] fis_status = 0, fis_error = 0;
  logic fis_accept, comreset_req, start_slot0;
  logic [SL-1:0] cmd_issue;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sata_port_ctl_reg #(.SLOTS(SL), .DW(32)) u_sata_port_ctl_reg (
    .clk(clk), .rst_n(rst_n), .stagger_cap(stagger_cap), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .init_done(init_done), .fis_valid(fis_valid), .fis_type(fis_type),
    .fis_status(fis_status), .fis_error(fis_error), .fis_accept(fis_accept),
    .rx_busy(rx_busy), .engine_idle(engine_idle), .comreset_req(comreset_req),
    .start_slot0(start_slot0), .cmd_issue(cmd_issue));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic fis(input logic [1:0] t, input logic [7:0] s, input logic [7:0] e);
    @(negedge clk); fis_valid = 1; fis_type = t; fis_status = s; fis_error = e;
    @(negedge clk); fis_valid = 0;
  endtask

  function automatic logic [31:0] rd(input logic [1:0] a);
    rd_addr = a;
    return 32'(0);
  endfunction

  task automatic rdchk(input string tag, input logic [1:0] a, input logic [31:0] mask, input logic [31:0] exp);
    rd_addr = a; #1;
    check(tag, rd_data & mask, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    rdchk("R1 ctl reset", 2'd0, 32'hFFFFFFFF, 32'h4);
    rdchk("R1 tf reset", 2'd1, 32'hFFFFFFFF, 32'h7F);
    rdchk("R1 ci reset", 2'd2, 32'hFFFFFFFF, 32'h0);
    rdchk("R1 addr3", 2'd3, 32'hFFFFFFFF, 32'h0);

    wr(2'd0, 32'h10);
    for (int i = 0; i < NV; i++) begin
      fis(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16]);
      rdchk("R11 table", 2'd1, 32'hFFFFFFFF, {16'h0, VEC[i][15:0]});
    end

    wr(2'd0, 32'h0); idle(2);
    fis(2'd2, 8'hFF, 8'hFF);
    rdchk("R2 sdb dropped", 2'd1, 32'hFFFF, 32'h0008);
    fis(2'd0, 8'h51, 8'h02);
    rdchk("R2 d2h dropped unarmed", 2'd1, 32'hFFFF, 32'h0008);
    @(negedge clk); init_done = 1; @(negedge clk); init_done = 0;
    fis(2'd1, 8'h50, 8'h00);
    rdchk("R3 pio not excepted", 2'd1, 32'hFFFF, 32'h0008);
    fis(2'd0, 8'h51, 8'h02);
    rdchk("R3 first d2h taken", 2'd1, 32'hFFFF, 32'h0251);
    fis(2'd0, 8'h00, 8'h00);
    rdchk("R3 second d2h dropped", 2'd1, 32'hFFFF, 32'h0251);

    wr(2'd0, 32'h10); idle(1);
    rdchk("R4 running set", 2'd0, 32'h4000, 32'h4000);
    rx_busy = 1;
    wr(2'd0, 32'h0); idle(2);
    rdchk("R4 held while busy", 2'd0, 32'h4000, 32'h4000);
    rx_busy = 0; idle(1);
    rdchk("R4 stopped", 2'd0, 32'h4000, 32'h0);

    wr(2'd0, 32'h10);
    fis(2'd1, 8'h88, 8'h00);
    rdchk("R11 pio busy", 2'd1, 32'hFFFF, 32'h0088);
    wr(2'd0, 32'h18);
    rdchk("R5 busy drq forced", 2'd1, 32'hFFFF, 32'h0000);
    rdchk("R5 override reads 1", 2'd0, 32'h8, 32'h8);
    idle(1);
    rdchk("R5 override self clears", 2'd0, 32'h8, 32'h0);
    fis(2'd1, 8'h88, 8'h00);
    wr(2'd0, 32'h10);
    rdchk("R5 write 0 no effect", 2'd1, 32'hFFFF, 32'h0088);
    wr(2'd0, 32'h0);
    rdchk("R6 pod reads 1", 2'd0, 32'h4, 32'h4);

    wr(2'd0, 32'h2);
    check("R8 comreset pulse", {31'h0, comreset_req}, 32'h1);
    rdchk("R7 spin bit rw", 2'd0, 32'h2, 32'h2);
    idle(1);
    check("R8 pulse one cycle", {31'h0, comreset_req}, 32'h0);
    wr(2'd0, 32'h2);
    check("R8 no repeat pulse", {31'h0, comreset_req}, 32'h0);
    wr(2'd0, 32'h0);
    rdchk("R7 spin bit clears", 2'd0, 32'h2, 32'h0);
    stagger_cap = 0;
    rdchk("R7 fixed 1 without cap", 2'd0, 32'h2, 32'h2);
    wr(2'd0, 32'h2);
    check("R8 no pulse without cap", {31'h0, comreset_req}, 32'h0);
    wr(2'd0, 32'h0);
    rdchk("R7 stays 1 without cap", 2'd0, 32'h2, 32'h2);
    stagger_cap = 1;

    wr(2'd2, 32'h3);
    rdchk("R12 ci ignored when stopped", 2'd2, 32'hFFFFFFFF, 32'h0);
    wr(2'd0, 32'h1);
    check("R9 start pulse", {31'h0, start_slot0}, 32'h1);
    idle(1);
    check("R9 pulse one cycle", {31'h0, start_slot0}, 32'h0);
    rdchk("R10 running flag", 2'd0, 32'h8000, 32'h8000);
    wr(2'd0, 32'h1);
    check("R9 no repeat pulse", {31'h0, start_slot0}, 32'h0);
    wr(2'd2, 32'h5);
    wr(2'd2, 32'h180);
    rdchk("R12 ci or top slot", 2'd2, 32'hFFFFFFFF, 32'h85);
    engine_idle = 0;
    wr(2'd0, 32'h0); idle(2);
    rdchk("R10 ci held until idle", 2'd2, 32'hFFFFFFFF, 32'h85);
    rdchk("R10 running held", 2'd0, 32'h8000, 32'h8000);
    engine_idle = 1; idle(1);
    check("R10 ci cleared", {24'h0, cmd_issue}, 32'h0);
    rdchk("R10 running cleared", 2'd0, 32'h8000, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule